// File: doc/BRIEF.md
# Frequency-Adaptive Duty Table Addresser

This block produces the read address for a table of precalculated duty values, one value per PWM cycle, spanning one half line period (a utility period) of 1000 entries. In place of a plain counter, it bends the address sequence to fit a utility period whose length, counted in PWM cycles, departs from the nominal 1000. A restart pulse marks the start of each utility period. With that pulse comes a signed deviation: the measured period length minus the nominal length, both counted in PWM cycles.

A positive deviation means the line frequency is low and the period is long, so the block presents chosen entries twice. A negative deviation means the period is short, so those same entries are skipped. The chosen entries are spread evenly across the table. A small lookup table, indexed by the deviation magnitude, gives the stride between them; the first chosen entry sits at half a stride. The duty values themselves are never recomputed. The address advances once per PWM-cycle tick. When the sequence is used up, the address parks on the last entry until the next restart.

Top module: `fdta_addresser`

## Requirements
- R1: While reset is asserted, and after it is released, addr_o is 0.
- R2: A restart pulse sets addr_o to 0 on the following cycle and captures dev_i. Changes on dev_i at any other time have no effect on the address sequence of the running period.
- R3: With a captured deviation of 0, successive ticks present the addresses 0, 1, ..., 999 in order, one step per tick.
- R4: addr_o changes only on a cycle with tick_i or restart_i high; otherwise it holds.
- R5: With a positive deviation m (dev_i is two's complement, positive = insert), let s = floor(1000/m). Each index s/2 + k*s, for k = 0..m-1, is presented on two consecutive ticks. Every other index is presented once, giving 1000+m entries.
- R6: With a negative deviation of magnitude m, each index s/2 + k*s (k = 0..m-1) is left out of the sequence. Every other index is presented once, giving 1000-m entries.
- R7: Once address 999 is reached, further ticks keep addr_o at 999 until the next restart.
- R8: A deviation magnitude above 60 is treated as 60, with its sign kept (+63 acts as +60, -64 acts as -60).
- R9: A restart during a running period, including one in the same cycle as a tick, abandons that period and starts the new sequence from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| restart_i | input | 1 | One-cycle pulse at the start of a utility period |
| tick_i | input | 1 | One-cycle pulse at the end of each PWM cycle |
| dev_i | input | 7 | Signed period deviation in PWM cycles, sampled with restart_i |
| addr_o | output | 10 | Duty table address for the current PWM cycle |

## Verification
The full tick-by-tick sequence is compared against an index list that the bench builds from the stride formula. This is done for a zero deviation, small and full-scale positive deviations, and small and full-scale negative deviations, which separates the stretch path, the shrink path and the plain path, and catches an off-by-one in the first index or the stride. Deviations beyond the limit in both signs show whether clamping keeps the sign. A dev_i change in mid-period, idle gaps between ticks, and a restart that coincides with a tick in mid-sequence each isolate a single capture or priority rule. Ticking past the end of each sequence shows whether the address parks at 999 rather than wrapping.

// File: rtl/fdta_pkg.sv
package fdta_pkg;

  typedef enum logic [1:0] {
    SEQ_PLAIN   = 2'd0,
    SEQ_STRETCH = 2'd1,
    SEQ_SHRINK  = 2'd2
  } seq_mode_e;

endpackage

// File: rtl/fdta_dev_latch.sv
module fdta_dev_latch
  import fdta_pkg::*;
#(
  parameter int DEV_W   = 7,
  parameter int MAX_DEV = 60,
  localparam int MAG_W  = $clog2(MAX_DEV + 1)
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    restart_i,
  input  logic signed [DEV_W-1:0] dev_i,
  output logic [MAG_W-1:0]        mag_d_o,
  output seq_mode_e               mode_q_o
);

  logic [DEV_W-1:0] mag_raw;
  seq_mode_e        mode_d;
  seq_mode_e        mode_q;

  always_comb begin
    if (dev_i[DEV_W-1]) begin
      mag_raw = ~dev_i + DEV_W'(1);
    end else begin
      mag_raw = dev_i;
    end
    if (mag_raw > DEV_W'(MAX_DEV)) begin
      mag_d_o = MAG_W'(MAX_DEV);
    end else begin
      mag_d_o = mag_raw[MAG_W-1:0];
    end
    if (dev_i == '0) begin
      mode_d = SEQ_PLAIN;
    end else if (dev_i[DEV_W-1]) begin
      mode_d = SEQ_SHRINK;
    end else begin
      mode_d = SEQ_STRETCH;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= SEQ_PLAIN;
    end else if (restart_i) begin
      mode_q <= mode_d;
    end
  end

  assign mode_q_o = mode_q;

  AST_MAG_CLAMP: assert property (@(posedge clk) disable iff (!rst_ni)
    mag_d_o <= MAG_W'(MAX_DEV)); // R8

endmodule

// File: rtl/fdta_stride_rom.sv
module fdta_stride_rom #(
  parameter int N_ENTRIES = 1000,
  parameter int MAX_DEV   = 60,
  localparam int MAG_W    = $clog2(MAX_DEV + 1),
  localparam int ADDR_W   = $clog2(N_ENTRIES),
  localparam int TAB_SZ   = 2 ** MAG_W
) (
  input  logic [MAG_W-1:0]  mag_i,
  output logic [ADDR_W-1:0] stride_o,
  output logic [ADDR_W-1:0] first_o
);

  logic [ADDR_W-1:0] stride_tab [TAB_SZ];

  for (genvar g = 0; g < TAB_SZ; g++) begin : g_tab
    localparam int MEFF = (g == 0) ? 1 : ((g > MAX_DEV) ? MAX_DEV : g);
    assign stride_tab[g] = ADDR_W'(N_ENTRIES / MEFF);
  end

  assign stride_o = stride_tab[mag_i];
  assign first_o  = stride_o >> 1;

endmodule

// File: rtl/fdta_mod_sched.sv
module fdta_mod_sched #(
  parameter int N_ENTRIES = 1000,
  parameter int MAX_DEV   = 60,
  localparam int MAG_W    = $clog2(MAX_DEV + 1),
  localparam int ADDR_W   = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              consume_i,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [ADDR_W-1:0] first_i,
  output logic [ADDR_W:0]   hit_o,
  output logic              pending_o
);

  logic [ADDR_W:0]   next_q,   next_d;
  logic [ADDR_W-1:0] stride_q, stride_d;
  logic [MAG_W-1:0]  left_q,   left_d;
  logic              sched_en;

  assign sched_en = restart_i | consume_i;

  always_comb begin
    next_d   = next_q;
    stride_d = stride_q;
    left_d   = left_q;
    if (restart_i) begin
      next_d   = {1'b0, first_i};
      stride_d = stride_i;
      left_d   = mag_i;
    end else if (consume_i) begin
      next_d = next_q + {1'b0, stride_q};
      left_d = left_q - MAG_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q   <= '0;
      stride_q <= '0;
      left_q   <= '0;
    end else if (sched_en) begin
      next_q   <= next_d;
      stride_q <= stride_d;
      left_q   <= left_d;
    end
  end

  assign hit_o     = next_q;
  assign pending_o = (left_q != '0);

  AST_CONSUME_PENDING: assert property (@(posedge clk) disable iff (!rst_ni)
    (consume_i && !restart_i) |-> pending_o); // R5

  AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    left_q <= MAG_W'(MAX_DEV)); // R8

  AST_HIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_ni)
    (consume_i && !restart_i) |=> (hit_o > $past(hit_o))); // R6

endmodule

// File: rtl/fdta_addr_seq.sv
module fdta_addr_seq
  import fdta_pkg::*;
#(
  parameter int N_ENTRIES = 1000,
  localparam int ADDR_W   = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              tick_i,
  input  seq_mode_e         mode_i,
  input  logic [ADDR_W:0]   hit_i,
  input  logic              pending_i,
  output logic              consume_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_ENTRIES - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W:0]   step1, step2;
  logic              addr_en;

  assign step1   = {1'b0, addr_q} + (ADDR_W + 1)'(1);
  assign step2   = {1'b0, addr_q} + (ADDR_W + 1)'(2);
  assign addr_en = restart_i | tick_i;

  always_comb begin
    addr_d    = addr_q;
    consume_o = 1'b0;
    if (restart_i) begin
      addr_d = '0;
    end else if (tick_i && (addr_q != LAST)) begin
      unique case (mode_i)
        SEQ_STRETCH: begin
          if (pending_i && (hit_i == {1'b0, addr_q})) begin
            consume_o = 1'b1;
          end else begin
            addr_d = step1[ADDR_W-1:0];
          end
        end
        SEQ_SHRINK: begin
          if (pending_i && (hit_i == step1) && (step1[ADDR_W-1:0] != LAST)) begin
            consume_o = 1'b1;
            addr_d    = step2[ADDR_W-1:0];
          end else begin
            addr_d = step1[ADDR_W-1:0];
          end
        end
        default: begin
          addr_d = step1[ADDR_W-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(addr_q)); // R4

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    restart_i |=> (addr_q == '0)); // R2

  AST_END_PARK: assert property (@(posedge clk) disable iff (!rst_ni)
    ((addr_q == LAST) && !restart_i) |=> (addr_q == LAST)); // R7

  AST_FORWARD_ONLY: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i && !restart_i) |=> ((addr_q >= $past(addr_q)) &&
                                ({1'b0, addr_q} <= {1'b0, $past(addr_q)} + (ADDR_W + 1)'(2)))); // R6

  AST_STRETCH_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    ((mode_i == SEQ_STRETCH) && tick_i && !restart_i) |=>
      ((addr_q - $past(addr_q)) <= ADDR_W'(1))); // R5

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    ((mode_i == SEQ_PLAIN) && tick_i && !restart_i && (addr_q != LAST)) |=>
      ((addr_q - $past(addr_q)) == ADDR_W'(1))); // R3

endmodule

// File: rtl/fdta_addresser.sv
module fdta_addresser
  import fdta_pkg::*;
#(
  parameter int N_ENTRIES = 1000,
  parameter int MAX_DEV   = 60,
  parameter int DEV_W     = 7,
  localparam int ADDR_W   = $clog2(N_ENTRIES),
  localparam int MAG_W    = $clog2(MAX_DEV + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart_i,
  input  logic                    tick_i,
  input  logic signed [DEV_W-1:0] dev_i,
  output logic [ADDR_W-1:0]       addr_o
);

  logic [1:0]        rst_pipe;
  logic              rst_ni;
  logic [MAG_W-1:0]  mag_d;
  seq_mode_e         mode_q;
  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] first;
  logic [ADDR_W:0]   hit;
  logic              pending;
  logic              consume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_ni = rst_pipe[1];

  fdta_dev_latch #(
    .DEV_W   (DEV_W),
    .MAX_DEV (MAX_DEV)
  ) u_dev (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .dev_i     (dev_i),
    .mag_d_o   (mag_d),
    .mode_q_o  (mode_q)
  );

  fdta_stride_rom #(
    .N_ENTRIES (N_ENTRIES),
    .MAX_DEV   (MAX_DEV)
  ) u_rom (
    .mag_i    (mag_d),
    .stride_o (stride),
    .first_o  (first)
  );

  fdta_mod_sched #(
    .N_ENTRIES (N_ENTRIES),
    .MAX_DEV   (MAX_DEV)
  ) u_sched (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .consume_i (consume),
    .mag_i     (mag_d),
    .stride_i  (stride),
    .first_i   (first),
    .hit_o     (hit),
    .pending_o (pending)
  );

  fdta_addr_seq #(
    .N_ENTRIES (N_ENTRIES)
  ) u_seq (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .tick_i    (tick_i),
    .mode_i    (mode_q),
    .hit_i     (hit),
    .pending_i (pending),
    .consume_o (consume),
    .addr_o    (addr_o)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    (!rst_ni) |=> (addr_o == '0)); // R1

endmodule

// File: tb/fdta_addresser_tb.sv
module fdta_addresser_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 1000;
  localparam int MAXD       = 60;
  localparam int SEQ_MAX    = N + MAXD;

  logic              clk;
  logic              rst_n;
  logic              restart_i;
  logic              tick_i;
  logic signed [6:0] dev_i;
  logic [9:0]        addr_o;

  int total;
  int bad;
  bit done;
  int exp_seq [SEQ_MAX];
  int exp_len;

  fdta_addresser u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_i),
    .tick_i    (tick_i),
    .dev_i     (dev_i),
    .addr_o    (addr_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // expected list built from the stride rule, dev already clamped by caller
  task automatic build_seq(input int dev);
    int m;
    int s;
    int f;
    m = (dev < 0) ? -dev : dev;
    s = (m == 0) ? N : N / m;
    f = s / 2;
    exp_len = 0;
    for (int i = 0; i < N; i++) begin
      bit hit;
      hit = (m != 0) && (i >= f) && (((i - f) % s) == 0) && (((i - f) / s) < m);
      if (hit && dev < 0) begin
        continue;
      end
      exp_seq[exp_len] = i;
      exp_len++;
      if (hit && dev > 0) begin
        exp_seq[exp_len] = i;
        exp_len++;
      end
    end
  endtask

  task automatic pulse_restart(input int dev);
    @(negedge clk);
    dev_i     = 7'(dev);
    restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
  endtask

  task automatic pulse_tick(input int gap);
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // runs one full period, compares every entry, then checks parking
  task automatic run_period(input string req, input int dev, input int eff, input int gap);
    int nbad;
    nbad = 0;
    build_seq(eff);
    pulse_restart(dev);
    for (int k = 0; k < exp_len; k++) begin
      if (k > 0) pulse_tick(gap);
      total++;
      if (addr_o != 10'(exp_seq[k])) begin
        nbad++;
        if (nbad == 1) begin
          bad++;
          $display("FAIL %s entry=%0d act=%0d exp=%0d", req, k, addr_o, exp_seq[k]);
        end
      end
    end
    check({req, " length"}, exp_len, N + eff);
    for (int k = 0; k < 4; k++) pulse_tick(0);
    check("R7 park at last entry", int'(addr_o), N - 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    restart_i = 1'b0;
    tick_i = 1'b0;
    dev_i = '0;
    repeat (3) @(negedge clk);
    check("R1 addr during reset", int'(addr_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 addr after reset", int'(addr_o), 0);
  endtask

  task automatic t_plain();
    run_period("R3 zero deviation", 0, 0, 0);
  endtask

  task automatic t_stretch();
    run_period("R5 insert dev=+12", 12, 12, 0);
    run_period("R5 insert dev=+60", 60, 60, 1);
    run_period("R5 insert dev=+1", 1, 1, 0);
  endtask

  task automatic t_shrink();
    run_period("R6 remove dev=-13", -13, -13, 0);
    run_period("R6 remove dev=-60", -60, -60, 0);
  endtask

  task automatic t_clamp();
    run_period("R8 clamp dev=+63", 63, 60, 0);
    run_period("R8 clamp dev=-64", -64, -60, 0);
  endtask

  task automatic t_idle();
    int held;
    pulse_restart(0);
    repeat (5) pulse_tick(0);
    held = int'(addr_o);
    check("R4 addr after 5 ticks", held, 5);
    repeat (20) @(negedge clk);
    check("R4 addr without ticks", int'(addr_o), held);
  endtask

  task automatic t_dev_ignored();
    int nbad;
    nbad = 0;
    build_seq(5);
    pulse_restart(5);
    dev_i = -7'sd30;
    for (int k = 0; k < exp_len; k++) begin
      if (k > 0) pulse_tick(0);
      if (k == 400) dev_i = 7'sd40;
      total++;
      if (addr_o != 10'(exp_seq[k])) begin
        nbad++;
        if (nbad == 1) begin
          bad++;
          $display("FAIL R2 dev change ignored entry=%0d act=%0d exp=%0d", k, addr_o, exp_seq[k]);
        end
      end
    end
  endtask

  task automatic t_abort();
    pulse_restart(20);
    repeat (300) pulse_tick(0);
    check("R9 mid-period progress", int'(addr_o) > 250 ? 1 : 0, 1);
    // restart in the same cycle as a tick
    @(negedge clk);
    dev_i     = -7'sd7;
    restart_i = 1'b1;
    tick_i    = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    tick_i    = 1'b0;
    check("R9 restart beats tick", int'(addr_o), 0);
    run_period("R9 new period after abort", -7, -7, 0);
  endtask

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    t_reset();
    t_plain();
    t_stretch();
    t_shrink();
    t_clamp();
    t_idle();
    t_dev_ignored();
    t_abort();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule